// File: doc/BRIEF.md
# Second-Group Operate Skip Evaluator

This block evaluates one second-group operate microinstruction of a 12-bit processor. With a valid strobe it takes the instruction word, the accumulator, the link bit and the current program counter. The counter is a 12-bit in-page address with a 3-bit field above it. One clock later the block returns four results and a flag:

- the skip decision
- the next program counter
- the accumulator, after any clear
- a request to set the halted state
- an illegal-instruction flag for the switch-register OR bit

A sense bit in the instruction chooses how the three condition tests combine. With the sense bit clear, the block skips when any enabled test holds. With it set, the block skips only when none of the enabled tests holds. Instruction fetch and memory access stay with the surrounding pipeline. That pipeline decides that the word belongs to this group before it raises the strobe.

Top module: `op2_skip_eval`

## Requirements
- R1: While reset is asserted and after its release, res_valid, res_skip, res_halt and res_illegal are 0, res_acc is 0 and res_pc is 0.
- R2: The outputs load one clock after in_valid is sampled high, and res_valid is high for exactly that cycle. In cycles without a strobe, res_valid is 0 and every other output keeps its last value.
- R3: With the sense bit (instr bit 3) clear, res_skip is 1 exactly when at least one of these holds. Bit 6 is set and acc bit 11 is 1 (negative). Bit 5 is set and acc is zero. Bit 4 is set and link is 1.
- R4: With the sense bit set, res_skip is 1 exactly when none of the three conditions of R3 holds. In particular, it is 1 when bits 6..4 are all clear.
- R5: When bit 7 (clear) is set, res_acc is 0; otherwise it equals acc. The tests of R3 and R4 always use the acc value from before the clear.
- R6: res_pc bits 11..0 are (pc_in + 1) mod 4096 without a skip and (pc_in + 2) mod 4096 with a skip. Bits 14..12 equal those of pc_in.
- R7: res_halt equals instr bit 1. A halt request does not change res_skip, res_pc or res_acc.
- R8: res_illegal equals instr bit 2 (switch-register OR). Every other output is still produced as R3 to R7 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: inputs hold an instruction to evaluate |
| instr | input | 12 | Instruction word |
| acc | input | 12 | Accumulator before the instruction |
| link | input | 1 | Link bit |
| pc_in | input | 15 | Current program counter: field (14..12) and address (11..0) |
| res_valid | output | 1 | Results valid this cycle |
| res_skip | output | 1 | Skip decision |
| res_pc | output | 15 | Next program counter |
| res_acc | output | 12 | Accumulator after the optional clear |
| res_halt | output | 1 | Request to set the halted state |
| res_illegal | output | 1 | Switch-register OR bit was used |

## Verification
The bench builds the block with its default widths: a 12-bit data path and a 3-bit field. At these widths the in-page wrap is easy to reach. Counter values 07776 and 07777, with and without a skip, show that the address wraps to zero while the field bits stay as they were. A 12-bit accumulator also lets the directed cases set the sign bit and the zero value exactly. Random words then cover every combination of the test, sense, clear, halt and illegal bits.

// File: rtl/op2_pkg.sv
package op2_pkg;
  // Bit positions inside the instruction word (behaviour depends on them)
  localparam int unsigned POS_CLR   = 7;
  localparam int unsigned POS_NEG   = 6;
  localparam int unsigned POS_ZERO  = 5;
  localparam int unsigned POS_LINK  = 4;
  localparam int unsigned POS_SENSE = 3;
  localparam int unsigned POS_SWOR  = 2;
  localparam int unsigned POS_HALT  = 1;

  typedef struct packed {
    logic clr;
    logic t_neg;
    logic t_zero;
    logic t_link;
    logic sense;
    logic swor;
    logic halt;
  } op2_fields_t;
endpackage

// File: rtl/op2_field_decode.sv
module op2_field_decode
  import op2_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] instr,
  output op2_fields_t       fields
);
  always_comb begin
    fields.clr    = instr[POS_CLR];
    fields.t_neg  = instr[POS_NEG];
    fields.t_zero = instr[POS_ZERO];
    fields.t_link = instr[POS_LINK];
    fields.sense  = instr[POS_SENSE];
    fields.swor   = instr[POS_SWOR];
    fields.halt   = instr[POS_HALT];
  end
endmodule

// File: rtl/op2_cond_eval.sv
module op2_cond_eval
  import op2_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  op2_fields_t       fields,
  input  logic [DATA_W-1:0] acc,
  input  logic              link,
  output logic              any_hit,
  output logic              skip
);
  localparam int unsigned SIGN_POS = DATA_W - 1;

  function automatic logic cond_hit(input op2_fields_t f,
                                    input logic [DATA_W-1:0] a,
                                    input logic l);
    logic neg_ok, zero_ok, link_ok;
    neg_ok  = f.t_neg  & a[SIGN_POS];
    zero_ok = f.t_zero & (a == '0);
    link_ok = f.t_link & l;
    return neg_ok | zero_ok | link_ok;
  endfunction

  always_comb begin
    any_hit = cond_hit(fields, acc, link);
    skip    = fields.sense ? ~any_hit : any_hit;
  end
endmodule

// File: rtl/op2_pc_step.sv
module op2_pc_step #(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned FIELD_W = 3
) (
  input  logic [FIELD_W+DATA_W-1:0] pc_in,
  input  logic                      skip,
  output logic [FIELD_W+DATA_W-1:0] pc_seq,
  output logic [FIELD_W+DATA_W-1:0] pc_next
);
  localparam int unsigned PC_W = FIELD_W + DATA_W;

  function automatic logic [PC_W-1:0] page_inc(input logic [PC_W-1:0] p);
    logic [DATA_W-1:0] low;
    low = p[DATA_W-1:0] + DATA_W'(1);
    return {p[PC_W-1:DATA_W], low};
  endfunction

  always_comb begin
    pc_seq  = page_inc(pc_in);
    pc_next = skip ? page_inc(pc_seq) : pc_seq;
  end
endmodule

// File: rtl/op2_skip_eval.sv
module op2_skip_eval
  import op2_pkg::*;
#(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned FIELD_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         instr,
  input  logic [DATA_W-1:0]         acc,
  input  logic                      link,
  input  logic [FIELD_W+DATA_W-1:0] pc_in,
  output logic                      res_valid,
  output logic                      res_skip,
  output logic [FIELD_W+DATA_W-1:0] res_pc,
  output logic [DATA_W-1:0]         res_acc,
  output logic                      res_halt,
  output logic                      res_illegal
);
  localparam int unsigned PC_W = FIELD_W + DATA_W;

  op2_fields_t       fields;
  logic              any_hit;
  logic              skip_now;
  logic [PC_W-1:0]   pc_seq;
  logic [PC_W-1:0]   pc_next;
  logic [DATA_W-1:0] acc_after;

  op2_field_decode #(.DATA_W(DATA_W)) u_decode (
    .instr  (instr),
    .fields (fields)
  );

  op2_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .fields  (fields),
    .acc     (acc),
    .link    (link),
    .any_hit (any_hit),
    .skip    (skip_now)
  );

  op2_pc_step #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_pc (
    .pc_in   (pc_in),
    .skip    (skip_now),
    .pc_seq  (pc_seq),
    .pc_next (pc_next)
  );

  // Clear is applied after the tests, which used the incoming acc
  assign acc_after = fields.clr ? '0 : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_skip    <= 1'b0;
      res_pc      <= '0;
      res_acc     <= '0;
      res_halt    <= 1'b0;
      res_illegal <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_skip    <= skip_now;
        res_pc      <= pc_next;
        res_acc     <= acc_after;
        res_halt    <= fields.halt;
        res_illegal <= fields.swor;
      end
    end
  end
endmodule

// File: rtl/op2_skip_eval_chk.sv
module op2_skip_eval_chk #(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned FIELD_W = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [DATA_W-1:0]         instr,
  input logic [DATA_W-1:0]         acc,
  input logic                      link,
  input logic [FIELD_W+DATA_W-1:0] pc_in,
  input logic                      res_valid,
  input logic                      res_skip,
  input logic [FIELD_W+DATA_W-1:0] res_pc,
  input logic [DATA_W-1:0]         res_acc,
  input logic                      res_halt,
  input logic                      res_illegal,
  input logic                      any_hit
);
  localparam int unsigned PC_W = FIELD_W + DATA_W;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_pc) && $stable(res_acc) && $stable(res_skip));
  p_plain_no_test_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !instr[3] && (instr[6:4] == 3'b000) |=> !res_skip);
  p_inverted_no_test_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr[3] && (instr[6:4] == 3'b000) |=> res_skip);
  p_skip_tracks_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_skip == ($past(any_hit) ^ $past(instr[3])));
  p_clear_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr[7] |=> res_acc == '0);
  p_keep_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !instr[7] |=> res_acc == $past(acc));
  p_old_acc_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !instr[3] && instr[5] && (acc == '0) |=> res_skip);
  p_field_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_pc[PC_W-1:DATA_W] == $past(pc_in[PC_W-1:DATA_W]));
  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_halt == $past(instr[1]));
  p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_illegal == $past(instr[2]));
endmodule

bind op2_skip_eval op2_skip_eval_chk #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .instr       (instr),
  .acc         (acc),
  .link        (link),
  .pc_in       (pc_in),
  .res_valid   (res_valid),
  .res_skip    (res_skip),
  .res_pc      (res_pc),
  .res_acc     (res_acc),
  .res_halt    (res_halt),
  .res_illegal (res_illegal),
  .any_hit     (any_hit)
);

// File: tb/op2_skip_eval_bench.sv
module op2_skip_eval_bench;
  localparam int unsigned DW = 12;
  localparam int unsigned FW = 3;
  localparam int unsigned PW = DW + FW;

  typedef struct {
    int          due;
    logic        skip;
    logic [PW-1:0] pc;
    logic [DW-1:0] acc;
    logic        halt;
    logic        illegal;
    logic        sense;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] instr = '0;
  logic [DW-1:0] acc = '0;
  logic          link = 1'b0;
  logic [PW-1:0] pc_in = '0;
  logic          res_valid, res_skip, res_halt, res_illegal;
  logic [PW-1:0] res_pc;
  logic [DW-1:0] res_acc;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  bit   have_last = 1'b0;
  exp_t last_item;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  op2_skip_eval u_op2_skip_eval (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .acc(acc),
    .link(link), .pc_in(pc_in), .res_valid(res_valid), .res_skip(res_skip),
    .res_pc(res_pc), .res_acc(res_acc), .res_halt(res_halt), .res_illegal(res_illegal)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [PW-1:0] step_pc(input logic [PW-1:0] p, input int n);
    int field, addr;
    field = int'(p) / 4096;
    addr  = (int'(p) % 4096 + n) % 4096;
    return PW'(field * 4096 + addr);
  endfunction

  task automatic drive(input logic [DW-1:0] w, input logic [DW-1:0] a,
                       input logic l, input logic [PW-1:0] p);
    exp_t e;
    int   hits;
    @(negedge clk);
    instr = w; acc = a; link = l; pc_in = p; in_valid = 1'b1;
    hits = 0;
    if (w[6] && a >= 12'd2048) hits++;
    if (w[5] && a == 12'd0)    hits++;
    if (w[4] && l)             hits++;
    e.sense   = w[3];
    e.skip    = w[3] ? (hits == 0) : (hits > 0);
    e.pc      = step_pc(p, e.skip ? 2 : 1);
    e.acc     = w[7] ? 12'd0 : a;
    e.halt    = w[1];
    e.illegal = w[2];
    e.due     = cyc + 1;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compares results against the scoreboard as they appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        check(res_valid == 1'b1, "R2 valid", res_valid, 1);
        check(res_skip == e.skip, e.sense ? "R4 skip" : "R3 skip", res_skip, e.skip);
        check(res_pc == e.pc, "R6 pc", res_pc, e.pc);
        check(res_acc == e.acc, "R5 acc", res_acc, e.acc);
        check(res_halt == e.halt, "R7 halt", res_halt, e.halt);
        check(res_illegal == e.illegal, "R8 illegal", res_illegal, e.illegal);
        last_item = e;
        have_last = 1'b1;
      end else begin
        check(res_valid == 1'b0, "R2 idle valid", res_valid, 0);
        if (have_last) begin
          check(res_pc == last_item.pc, "R2 hold pc", res_pc, last_item.pc);
          check(res_acc == last_item.acc, "R2 hold acc", res_acc, last_item.acc);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(res_valid == 0 && res_skip == 0 && res_halt == 0 && res_illegal == 0,
          "R1 flags", {res_valid, res_skip, res_halt, res_illegal}, 0);
    check(res_pc == 0 && res_acc == 0, "R1 data", res_pc ^ res_acc, 0);
    rst_n = 1'b1;
    idle(2);

    // R3: each test alone, plain sense
    drive(12'o7500, 12'o4000, 1'b0, 15'o10100); // negative test, negative acc
    drive(12'o7500, 12'o3777, 1'b0, 15'o10100); // negative test, positive acc
    drive(12'o7440, 12'o0000, 1'b0, 15'o20200); // zero test, zero acc
    drive(12'o7440, 12'o0001, 1'b0, 15'o20200);
    drive(12'o7420, 12'o0005, 1'b1, 15'o30300); // link test
    drive(12'o7420, 12'o0005, 1'b0, 15'o30300);
    drive(12'o7400, 12'o4000, 1'b1, 15'o00400); // no tests: no skip
    idle(1);
    // R4: inverted sense
    drive(12'o7410, 12'o0000, 1'b1, 15'o40500); // no tests: always skip
    drive(12'o7510, 12'o4000, 1'b0, 15'o40500);
    drive(12'o7510, 12'o0001, 1'b0, 15'o40500);
    drive(12'o7450, 12'o0000, 1'b0, 15'o50600);
    drive(12'o7430, 12'o0007, 1'b1, 15'o50600);
    drive(12'o7570, 12'o0001, 1'b0, 15'o60700);
    idle(2);
    // R5: clear uses old acc for tests
    drive(12'o7640, 12'o0000, 1'b0, 15'o00010);
    drive(12'o7640, 12'o0123, 1'b0, 15'o00010);
    drive(12'o7710, 12'o4321, 1'b0, 15'o00010);
    // R6: in-page wrap keeps field
    drive(12'o7400, 12'o0001, 1'b0, 15'o57777);
    drive(12'o7410, 12'o0001, 1'b0, 15'o57777);
    drive(12'o7410, 12'o0001, 1'b0, 15'o77776);
    drive(12'o7400, 12'o0001, 1'b0, 15'o77776);
    // R7: halt alongside skip
    drive(12'o7402, 12'o0001, 1'b0, 15'o01000);
    drive(12'o7442, 12'o0000, 1'b0, 15'o01000);
    // R8: switch-register OR flagged, results still produced
    drive(12'o7404, 12'o0000, 1'b0, 15'o02000);
    drive(12'o7654, 12'o0000, 1'b0, 15'o02000);
    idle(3);
    // Random mix, all bit combinations of the group
    for (int i = 0; i < 300; i++) begin
      logic [DW-1:0] w;
      w = DW'($urandom) | 12'o7400;
      w[0] = 1'b0;
      drive(w, ($urandom % 4 == 0) ? 12'd0 : DW'($urandom), 1'($urandom),
            PW'($urandom));
      if ($urandom % 5 == 0) idle(1);
    end
    idle(3);
    check(sb.size() == 0, "R2 all results seen", sb.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule